// File: doc/BRIEF.md
# GPIO Port with Wake-Event Logic

This block is a bank of general-purpose I/O bits behind a small register interface. Each bit has a two-bit configuration register. One field picks the direction and the other picks the polarity. One shared data register holds the value written for the bits set as outputs. The polarity field inverts the value driven on an output pin. It also inverts the value the host reads back from an input pin.

Pin inputs go through a two-flop synchronizer. On input bits, an edge-detection stage then watches for the edge that the polarity field selects. A detected edge sets a sticky event status bit, and the host clears that bit by writing a 1 to it. A per-bit enable register and a global enable combine with the status bits to raise a single wake request.

Top module: `gpio_wake_port`

## Requirements
- R1: After reset, every bit is an input: `pin_oe` is 0, config reads 1 (bit 0 = 1 input, bit 1 = 0 polarity), and data, status, enable and global enable read 0. `wake_req` is 0. The register map is: address 0 = data, 1 = event status, 2 = event enable, 3 = global enable (bit 0), 4+i = config of bit i.
- R2: A read returns its data on `host_rdata` one cycle after the `host_rd` strobe, and `host_rdata` holds its value when no read is made. On a data read, an input bit returns the synchronized pin value, inverted when its polarity bit is 1.
- R3: A host write to the data register leaves every bit that is currently an input unchanged. This holds for the pin drive and for the stored value, even after the bit later becomes an output.
- R4: A bit with config bit 0 = 0 drives `pin_oe` = 1 and `pin_out` = its data bit, inverted when config bit 1 = 1.
- R5: On a data read, an output bit returns the last value written to its data bit, never inverted.
- R6: On an input bit, a rising edge of the synchronized pin sets its status bit when polarity = 0, and a falling edge sets it when polarity = 1. The edge of the other direction does not set it.
- R7: A bit configured as an output never sets its status bit, whatever its pin does.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an edge arrives in the same cycle as the clearing write, the bit stays set.
- R9: `wake_req` is 1 exactly when the global enable is 1 and at least one bit has both its status and its enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | AW | Register address |
| host_wdata | input | NBITS | Write data |
| host_rdata | output | NBITS | Read data, registered |
| pin_in | input | NBITS | Pin input values |
| pin_out | output | NBITS | Pin drive values |
| pin_oe | output | NBITS | Pin output enables |
| wake_req | output | 1 | Wake request |

## Verification
A wrong direction or polarity state shows at once on `pin_oe` and `pin_out`. It also shows in the next data read. A corrupted edge history or status bit shows on `wake_req` in the cycle after the bad edge decision, once the bit is enabled. It also shows in the status read that follows. The reference model tracks the synchronizer delay, so an event that lands one cycle early or late is caught on `wake_req` in that very cycle. The bench also drives a clearing write into the exact cycle of an edge to check which of the two takes priority.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
  localparam int unsigned ADR_DATA = 0;
  localparam int unsigned ADR_STS  = 1;
  localparam int unsigned ADR_EN   = 2;
  localparam int unsigned ADR_GEN  = 3;
  localparam int unsigned ADR_CFG0 = 4;

  // bit 1: polarity (1 = inverted), bit 0: direction (1 = input)
  typedef struct packed {
    logic pol;
    logic is_in;
  } gpio_cfg_t;

  localparam gpio_cfg_t CFG_RESET = '{pol: 1'b0, is_in: 1'b1};
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic st1_q, st2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st1_q <= 1'b0;
      st2_q <= 1'b0;
    end else begin
      st1_q <= 1'b1;
      st2_q <= st1_q;
    end
  end

  assign rst_n_o = st2_q;
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/gpio_event.sv
module gpio_event #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] is_in_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] sts_q, sts_d;
  logic [W-1:0] rise, fall, hit;

  always_comb begin
    rise  = sync_i & ~prev_q;
    fall  = ~sync_i & prev_q;
    hit   = is_in_i & ((rise & ~pol_i) | (fall & pol_i));
    sts_d = (sts_q & ~clr_i) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      sts_q  <= '0;
    end else begin
      prev_q <= sync_i;
      sts_q  <= sts_d;
    end
  end

  assign sts_o = sts_q;

  // R7: a newly set status bit must have been an input bit
  p_out_never_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q) & ~$past(is_in_i)) == '0));

  // R8: a set bit without a clear stays set
  p_keep_unless_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sts_q & ~clr_i) & ~sts_q) == '0));

  // R8: a cleared bit with no edge in that cycle reads 0
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clr_i & ~hit) & sts_q) == '0));
endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
  import gpio_wake_pkg::*;
#(
  parameter int unsigned NBITS = 8,
  parameter int unsigned AW    = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [AW-1:0]    host_addr,
  input  logic [NBITS-1:0] host_wdata,
  output logic [NBITS-1:0] host_rdata,
  input  logic [NBITS-1:0] pin_in,
  output logic [NBITS-1:0] pin_out,
  output logic [NBITS-1:0] pin_oe,
  output logic             wake_req
);
  localparam int unsigned CFG_PAD = NBITS - 2;

  logic             rst_n;
  logic [NBITS-1:0] sync_v;
  logic [NBITS-1:0] sts_v;
  logic [NBITS-1:0] dout_q, dout_d;
  logic [NBITS-1:0] en_q, en_d;
  logic             gen_q, gen_d;
  gpio_cfg_t        cfg_q [NBITS];
  gpio_cfg_t        cfg_d [NBITS];
  logic [NBITS-1:0] is_in_v, pol_v;
  logic [NBITS-1:0] rdata_q, rdata_d, rd_sel;
  logic [NBITS-1:0] clr_v;
  logic             wr_data, wr_sts, wr_en, wr_gen;

  gpio_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n_o(rst_n));

  gpio_sync #(.W(NBITS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_in), .q_o(sync_v)
  );

  gpio_event #(.W(NBITS)) u_event (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_v), .is_in_i(is_in_v),
    .pol_i(pol_v), .clr_i(clr_v), .sts_o(sts_v)
  );

  assign wr_data = host_wr && (host_addr == AW'(ADR_DATA));
  assign wr_sts  = host_wr && (host_addr == AW'(ADR_STS));
  assign wr_en   = host_wr && (host_addr == AW'(ADR_EN));
  assign wr_gen  = host_wr && (host_addr == AW'(ADR_GEN));
  assign clr_v   = wr_sts ? host_wdata : '0;

  for (genvar i = 0; i < NBITS; i++) begin : g_cfg
    logic wr_cfg;
    assign wr_cfg     = host_wr && (host_addr == AW'(ADR_CFG0 + i));
    assign cfg_d[i]   = wr_cfg ? gpio_cfg_t'(host_wdata[1:0]) : cfg_q[i];
    assign is_in_v[i] = cfg_q[i].is_in;
    assign pol_v[i]   = cfg_q[i].pol;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[i] <= CFG_RESET;
      else        cfg_q[i] <= cfg_d[i];
    end
  end

  // next-state logic
  always_comb begin
    dout_d = wr_data ? ((dout_q & is_in_v) | (host_wdata & ~is_in_v)) : dout_q;
    en_d   = wr_en ? host_wdata : en_q;
    gen_d  = wr_gen ? host_wdata[0] : gen_q;

    rd_sel = '0;
    if (host_addr == AW'(ADR_DATA))
      rd_sel = ((sync_v ^ pol_v) & is_in_v) | (dout_q & ~is_in_v);
    else if (host_addr == AW'(ADR_STS))
      rd_sel = sts_v;
    else if (host_addr == AW'(ADR_EN))
      rd_sel = en_q;
    else if (host_addr == AW'(ADR_GEN))
      rd_sel = {{(NBITS-1){1'b0}}, gen_q};
    for (int i = 0; i < NBITS; i++) begin
      if (host_addr == AW'(ADR_CFG0 + i))
        rd_sel = {{CFG_PAD{1'b0}}, cfg_q[i]};
    end
    rdata_d = host_rd ? rd_sel : rdata_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      en_q    <= '0;
      gen_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      dout_q  <= dout_d;
      en_q    <= en_d;
      gen_q   <= gen_d;
      rdata_q <= rdata_d;
    end
  end

  assign host_rdata = rdata_q;
  assign pin_out    = dout_q ^ pol_v;
  assign pin_oe     = ~is_in_v;
  assign wake_req   = gen_q & (|(sts_v & en_q));

  // R3: a data write never changes bits that were inputs
  p_input_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_data) |-> (((dout_q ^ $past(dout_q)) & $past(is_in_v)) == '0));

  // R2: read data holds when no read was strobed
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(host_rd) |-> $stable(host_rdata));

  // R9: no wake while the global enable is off
  p_wake_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |-> !wake_req);
endmodule

// File: tb/gpio_wake_port_tb_top.sv
module gpio_wake_port_tb_top;
  localparam int NB = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic          host_wr = 1'b0, host_rd = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [NB-1:0] host_wdata = '0, pin_in = '0;
  logic [NB-1:0] host_rdata, pin_out, pin_oe;
  logic          wake_req;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_wake_port #(.NBITS(NB), .AW(AW)) dut_i (
    .clk(clk), .arst_n(arst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .wake_req(wake_req)
  );

  // behavioural reference model
  int m_dir[NB], m_pol[NB], m_data[NB], m_sts[NB], m_en[NB];
  int m_a[NB], m_b[NB], m_prev[NB];
  int m_gen, m_live;
  logic [NB-1:0] m_rdata;

  function automatic logic [NB-1:0] m_read(int a);
    logic [NB-1:0] v = '0;
    for (int i = 0; i < NB; i++) begin
      case (a)
        0: v[i] = (m_dir[i] != 0) ? ((m_b[i] ^ m_pol[i]) != 0) : (m_data[i] != 0);
        1: v[i] = m_sts[i] != 0;
        2: v[i] = m_en[i] != 0;
        default: ;
      endcase
    end
    if (a == 3) v[0] = m_gen != 0;
    if (a >= 4 && a < 4 + NB) begin
      v[0] = m_dir[a-4] != 0;
      v[1] = m_pol[a-4] != 0;
    end
    return v;
  endfunction

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int i = 0; i < NB; i++) begin
        m_dir[i] = 1; m_pol[i] = 0; m_data[i] = 0; m_sts[i] = 0; m_en[i] = 0;
        m_a[i] = 0; m_b[i] = 0; m_prev[i] = 0;
      end
      m_gen = 0; m_live = 0; m_rdata = '0;
    end else if (m_live < 2) begin
      m_live++;
    end else begin
      int ev[NB];
      int a;
      a = int'(host_addr);
      if (host_rd) m_rdata = m_read(a);
      for (int i = 0; i < NB; i++) begin
        ev[i] = 0;
        if (m_dir[i] != 0) begin
          if (m_pol[i] == 0 && m_prev[i] == 0 && m_b[i] == 1) ev[i] = 1;
          if (m_pol[i] == 1 && m_prev[i] == 1 && m_b[i] == 0) ev[i] = 1;
        end
        if (host_wr && a == 1 && host_wdata[i]) m_sts[i] = 0;
        if (ev[i] != 0) m_sts[i] = 1;
        m_prev[i] = m_b[i]; m_b[i] = m_a[i]; m_a[i] = int'(pin_in[i]);
      end
      if (host_wr) begin
        for (int i = 0; i < NB; i++) begin
          if (a == 0 && m_dir[i] == 0) m_data[i] = int'(host_wdata[i]);
          if (a == 2) m_en[i] = int'(host_wdata[i]);
        end
        if (a == 3) m_gen = int'(host_wdata[0]);
        if (a >= 4 && a < 4 + NB) begin
          m_dir[a-4] = int'(host_wdata[0]);
          m_pol[a-4] = int'(host_wdata[1]);
        end
      end
    end
  end

  task automatic chk(string req, logic [NB-1:0] act, logic [NB-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (arst_n && !done) begin
      logic [NB-1:0] eo, ep;
      int any;
      any = 0;
      for (int i = 0; i < NB; i++) begin
        eo[i] = m_dir[i] == 0;
        ep[i] = (m_data[i] ^ m_pol[i]) != 0;
        if (m_sts[i] != 0 && m_en[i] != 0) any = 1;
      end
      chk("R4 pin_oe", pin_oe, eo);
      chk("R4 pin_out", pin_out, ep);
      chk("R2 host_rdata", host_rdata, m_rdata);
      chk("R9 wake_req", {{(NB-1){1'b0}}, wake_req},
          {{(NB-1){1'b0}}, (m_gen != 0 && any != 0)});
    end
  end

  task automatic wr(int a, logic [NB-1:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [NB-1:0] v);
    @(negedge clk);
    host_rd = 1'b1; host_addr = AW'(a);
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [NB-1:0] v;
    idle(3);
    arst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 wake", {7'b0, wake_req}, 8'h00);
    rd(4, v);  chk("R1 cfg0", v, 8'h01);
    rd(0, v);  chk("R1 data", v, 8'h00);
    rd(1, v);  chk("R1 status", v, 8'h00);
    rd(3, v);  chk("R1 gen", v, 8'h00);
    // R2 input reads, R6 rising edges set status
    @(negedge clk); pin_in = 8'hA5;
    idle(4);
    rd(0, v);  chk("R2 input read", v, 8'hA5);
    wr(4 + 3, 8'h03);
    rd(0, v);  chk("R2 inverted read", v, 8'hAD);
    rd(1, v);  chk("R6 rising set", v, 8'hA5);
    // R8 clear
    wr(1, 8'h05); rd(1, v); chk("R8 w1c", v, 8'hA0);
    wr(1, 8'h00); rd(1, v); chk("R8 write 0 keeps", v, 8'hA0);
    wr(1, 8'hFF); rd(1, v); chk("R8 clear all", v, 8'h00);
    // R6 falling edge selected on bit 3
    @(negedge clk); pin_in = 8'hAD;
    idle(4);
    rd(1, v);  chk("R6 rise ignored with pol=1", v, 8'h00);
    @(negedge clk); pin_in = 8'hA5;
    idle(4);
    rd(1, v);  chk("R6 falling set", v, 8'h08);
    // R9 wake
    wr(2, 8'h08);
    chk("R9 no gen", {7'b0, wake_req}, 8'h00);
    wr(3, 8'h01);
    chk("R9 wake on", {7'b0, wake_req}, 8'h01);
    wr(2, 8'h00);
    chk("R9 enable off", {7'b0, wake_req}, 8'h00);
    wr(2, 8'h08); wr(1, 8'h08);
    chk("R9 cleared", {7'b0, wake_req}, 8'h00);
    // R4 / R5 output bit 1
    wr(4 + 1, 8'h00);
    wr(0, 8'h02);
    chk("R4 oe bit1", pin_oe, 8'h02);
    chk("R4 drive bit1", pin_out & 8'h02, 8'h02);
    wr(4 + 1, 8'h02);
    chk("R4 inverted drive", pin_out & 8'h02, 8'h00);
    rd(0, v);  chk("R5 output readback", v, 8'hAF);
    // R7 output pin toggles do not set status
    @(negedge clk); pin_in = 8'hA7; idle(4);
    @(negedge clk); pin_in = 8'hA5; idle(4);
    rd(1, v);  chk("R7 output no event", v, 8'h00);
    // R3 writes to inputs ignored
    wr(0, 8'hFF);
    wr(4 + 0, 8'h00);
    chk("R3 bit0 drive stays 0", pin_out & 8'h01, 8'h00);
    rd(0, v);  chk("R3 readback", v, 8'hAE);
    // R8 edge and clear in the same cycle
    @(negedge clk); pin_in = 8'hB5; idle(4);
    rd(1, v);  chk("R6 bit4 set", v, 8'h10);
    @(negedge clk); pin_in = 8'hA5; idle(4);
    @(negedge clk); pin_in = 8'hB5;
    @(negedge clk);
    wr(1, 8'h10);
    rd(1, v);  chk("R8 edge wins over clear", v, 8'h10);
    wr(1, 8'h10);
    rd(1, v);  chk("R8 clear later", v, 8'h00);
    idle(3);
    finish_run();
  end
endmodule